// File: doc/BRIEF.md
# Bit Clock and Data Recovery

This unit sits behind a demodulator that delivers one raw decision per sample strobe, several strobes per symbol. It cleans that stream and rebuilds a bit clock for a continuous-mode data pin. A three-sample majority vote first removes isolated wrong samples. A per-sample phase counter then runs at the nominal number of samples per bit. Each transition of the filtered stream moves the counter back to the point that puts the next sample decision at mid-bit.

The data output only changes as the recovered clock falls, and the clock stays high for the second half of each bit period. A receiver that latches data on the rising clock edge therefore always sees a settled bit. When no transitions arrive, the counter keeps running at the nominal ratio, so the clock continues. A disable input bypasses recovery. In that mode the clock is held low and the raw input goes straight to the data output. The unit is meant for the direct bit-by-bit data mode only.

Top module: `dcr_recover`

## Requirements
- R1: While `rst_n` is low, `dat_out` and `clk_out` are 0 with `rec_dis` low, whatever `raw_in` does.
- R2: With `rec_dis` high, `clk_out` is 0 and `dat_out` equals `raw_in` combinationally in the same cycle.
- R3: With `rec_dis` low, `dat_out` changes only in the cycle where `clk_out` goes from 1 to 0, so it is stable across every rising edge of `clk_out`.
- R4: A single strobe sample of the opposite level inside a steady input never reaches `dat_out` (majority of the last three strobe samples).
- R5: With a steady input, `clk_out` has a period of R strobes and is high for R - floor(R/2) strobes of it, where R is the effective ratio.
- R6: The effective ratio R is `ratio` limited to the range 8 to 32: values below 8 act as 8, values above 32 act as 32.
- R7: For bits of exactly R strobes each, the `dat_out` values taken at the rising edges of `clk_out` reproduce the transmitted bit sequence in order.
- R8: Bits whose lengths vary by one strobe either way, with the accumulated drift kept within one strobe, are still recovered in order as in R7.
- R9: All counting advances only on cycles with `smp_en` high. With a strobe every second clock, the `clk_out` period measured in clocks doubles.
- R10: After a steady level, a change of `raw_in` appears on `dat_out` at the clock edge R - floor(R/2) strobes after the strobe edge that first samples the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_en | input | 1 | Sample strobe, one per oversampled input sample |
| raw_in | input | 1 | Raw demodulated data decision |
| ratio | input | RATIO_W (6) | Nominal samples per bit |
| rec_dis | input | 1 | 1 bypasses recovery |
| dat_out | output | 1 | Recovered NRZ data, or the raw input in bypass |
| clk_out | output | 1 | Recovered bit clock, held low in bypass |

## Verification
The main recovery path is driven with random bit strings at random ratios and strobe spacings, both at exact nominal bit length and with bounded one-strobe jitter. These runs separate correct mid-bit phase tracking from a counter that only free-runs or that drifts. Steady inputs at several ratios, including values outside the legal range, isolate the free-running period, the high time and the clamping. A single step after a long steady level measures the exact resynchronisation latency, and a single-sample pulse of either polarity shows whether the majority filter rejects glitches. Random raw data in bypass separates the pass-through from the recovered path.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  // samples in the majority window
  localparam int unsigned VOTE_N   = 3;
  // strobes between a raw level change and its detection as a filtered edge
  localparam int unsigned FILT_LAT = 2;
endpackage

// File: rtl/dcr_rst_sync.sv
module dcr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/dcr_vote_filter.sv
module dcr_vote_filter #(
  parameter int unsigned N = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic raw,
  output logic filt
);
  logic [N-2:0] hist_q, hist_d;
  logic         filt_q, filt_d;
  logic [N-1:0] win;
  logic         maj;

  assign win = {hist_q, raw};
  assign maj = ($countones(win) > (N / 2));

  always_comb begin
    hist_d = hist_q;
    filt_d = filt_q;
    if (smp_en) begin
      hist_d = win[N-2:0];
      filt_d = maj;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      hist_q <= hist_d;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;
endmodule

// File: rtl/dcr_phase_track.sv
module dcr_phase_track
  import dcr_pkg::*;
#(
  parameter int unsigned RATIO_W   = 6,
  parameter int unsigned MIN_RATIO = 8,
  parameter int unsigned MAX_RATIO = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_en,
  input  logic               dis,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               filt,
  output logic               clk_rec,
  output logic               dat_rec
);
  localparam int unsigned CNT_W = $clog2(MAX_RATIO);

  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               dat_q, dat_d;
  logic               prev_q, prev_d;
  logic [RATIO_W-1:0] ratio_c, half, reload, cnt_x;
  logic               wrap, edge_hit;

  always_comb begin
    if (ratio < RATIO_W'(MIN_RATIO))      ratio_c = RATIO_W'(MIN_RATIO);
    else if (ratio > RATIO_W'(MAX_RATIO)) ratio_c = RATIO_W'(MAX_RATIO);
    else                                  ratio_c = ratio;
  end

  assign half     = ratio_c >> 1;
  // reload places the next wrap at mid-bit, allowing for filter delay
  assign reload   = half + RATIO_W'(FILT_LAT);
  assign cnt_x    = RATIO_W'(cnt_q);
  assign wrap     = (cnt_x >= (ratio_c - 1'b1));
  assign edge_hit = (filt != prev_q);

  always_comb begin
    cnt_d  = cnt_q;
    dat_d  = dat_q;
    prev_d = prev_q;
    if (dis) begin
      cnt_d  = '0;
      prev_d = filt;
    end else if (smp_en) begin
      prev_d = filt;
      if (edge_hit) begin
        cnt_d = CNT_W'(reload);
      end else if (wrap) begin
        cnt_d = '0;
        dat_d = filt;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dat_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dat_q  <= dat_d;
      prev_q <= prev_d;
    end
  end

  assign clk_rec = !dis && (cnt_x >= half);
  assign dat_rec = dat_q;
endmodule

// File: rtl/dcr_recover.sv
module dcr_recover
  import dcr_pkg::*;
#(
  parameter int unsigned RATIO_W   = 6,
  parameter int unsigned MIN_RATIO = 8,
  parameter int unsigned MAX_RATIO = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_en,
  input  logic               raw_in,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               rec_dis,
  output logic               dat_out,
  output logic               clk_out
);
  logic srst_n;
  logic filt_w;
  logic clk_w;
  logic dat_w;

  dcr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  dcr_vote_filter #(.N(VOTE_N)) u_filt (
    .clk    (clk),
    .rst_n  (srst_n),
    .smp_en (smp_en),
    .raw    (raw_in),
    .filt   (filt_w)
  );

  dcr_phase_track #(
    .RATIO_W   (RATIO_W),
    .MIN_RATIO (MIN_RATIO),
    .MAX_RATIO (MAX_RATIO)
  ) u_trk (
    .clk     (clk),
    .rst_n   (srst_n),
    .smp_en  (smp_en),
    .dis     (rec_dis),
    .ratio   (ratio),
    .filt    (filt_w),
    .clk_rec (clk_w),
    .dat_rec (dat_w)
  );

  assign dat_out = rec_dis ? raw_in : dat_w;
  assign clk_out = clk_w;
endmodule

// File: rtl/dcr_recover_chk.sv
module dcr_recover_chk (
  input logic clk,
  input logic rst_n,
  input logic smp_en,
  input logic raw_in,
  input logic rec_dis,
  input logic dat_out,
  input logic clk_out,
  input logic filt
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R2
  a_r2_bypass_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    rec_dis |-> (!clk_out && (dat_out == raw_in)));

  // R3
  a_r3_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !rec_dis && !$past(rec_dis) && (dat_out != $past(dat_out)))
      |-> ($past(clk_out) && !clk_out));

  // R9
  a_r9_clk_moves_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !rec_dis && !$past(rec_dis) && (clk_out != $past(clk_out)))
      |-> $past(smp_en));

  // R4
  a_r4_filter_follows_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (filt != $past(filt)))
      |-> ($past(smp_en) && ($past(raw_in) == filt)));
endmodule

bind dcr_recover dcr_recover_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .smp_en  (smp_en),
  .raw_in  (raw_in),
  .rec_dis (rec_dis),
  .dat_out (dat_out),
  .clk_out (clk_out),
  .filt    (filt_w)
);

// File: tb/tb_dcr_recover.sv
module tb_dcr_recover;
  logic       clk;
  logic       rst_n;
  logic       smp_en;
  logic       raw_in;
  logic [5:0] ratio;
  logic       rec_dis;
  logic       dat_out;
  logic       clk_out;

  int checks = 0;
  int fails  = 0;
  int sdiv   = 1;
  bit done   = 0;

  int cyc = 0, last_rise = 0, last_period = 0, high_run = 0, last_high = 0;
  int viol = 0, cnt1 = 0, cnt0 = 0, rec_n = 0;
  bit rec [0:127];
  bit rec_en = 0;
  logic pclk = 0, pdat = 0, pdis = 0;

  dcr_recover dut (
    .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .raw_in(raw_in),
    .ratio(ratio), .rec_dis(rec_dis), .dat_out(dat_out), .clk_out(clk_out)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // observation, 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    cyc++;
    if (rst_n) begin
      if (!rec_dis && !pdis && (dat_out !== pdat) && !(pclk && !clk_out)) viol++;
      if (clk_out && !pclk) begin
        last_period = cyc - last_rise;
        last_rise   = cyc;
        if (rec_en && rec_n < 128) begin
          rec[rec_n] = dat_out;
          rec_n++;
        end
      end
      if (clk_out) high_run++;
      else if (pclk) begin
        last_high = high_run;
        high_run  = 0;
      end
      if (dat_out) cnt1++; else cnt0++;
    end
    pclk = clk_out;
    pdat = dat_out;
    pdis = rec_dis;
  end

  function automatic int eff(input int r);
    if (r < 8)  return 8;
    if (r > 32) return 32;
    return r;
  endfunction

  function automatic int exp_period(input int r, input int d);
    return eff(r) * d;
  endfunction

  function automatic int exp_high(input int r, input int d);
    return (eff(r) - eff(r) / 2) * d;
  endfunction

  function automatic int exp_lat(input int r);
    return eff(r) - eff(r) / 2 + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic b);
    for (int i = 0; i < sdiv; i++) begin
      @(negedge clk);
      raw_in = b;
      smp_en = (i == 0);
    end
  endtask

  task automatic hold(input logic b, input int n);
    for (int i = 0; i < n; i++) strobe(b);
  endtask

  task automatic free_run(input int r, input int d, input string req);
    ratio = 6'(r);
    sdiv  = d;
    hold(1'b0, 4 * eff(r) + 2);
    chk(last_period == exp_period(r, d), req, last_period, exp_period(r, d));
    chk(last_high == exp_high(r, d), req, last_high, exp_high(r, d));
  endtask

  task automatic latency(input int r);
    int n;
    ratio = 6'(r);
    sdiv  = 1;
    hold(1'b0, 4 * r);
    @(negedge clk);
    raw_in = 1'b1;
    smp_en = 1'b1;
    n = 0;
    do begin
      @(posedge clk);
      #5;
      n++;
    end while (dat_out !== 1'b1 && n < 200);
    chk(n == exp_lat(r), "R10", n, exp_lat(r));
    hold(1'b1, 2 * r);
  endtask

  task automatic recovery(input bit jitter, input string req);
    int  r, nb, drift, d, len, hit;
    bit  sent [0:39];
    r     = jitter ? 10 + int'($urandom % 23) : 8 + int'($urandom % 25);
    sdiv  = 1 + int'($urandom % 2);
    ratio = 6'(r);
    nb    = 0;
    for (int i = 0; i < 8; i++) begin sent[nb] = i[0]; nb++; end
    for (int i = 0; i < 20; i++) begin sent[nb] = 1'($urandom % 2); nb++; end
    for (int i = 0; i < 3; i++) begin sent[nb] = 1'($urandom % 2); nb++; end
    rec_n  = 0;
    rec_en = 1;
    drift  = 0;
    for (int i = 0; i < nb; i++) begin
      d = 0;
      if (jitter) begin
        d = int'($urandom % 3) - 1;
        if (drift + d > 1 || drift + d < -1) d = -d;
        drift += d;
      end
      len = r + d;
      hold(sent[i], len);
    end
    rec_en = 0;
    hit = 0;
    for (int k = 0; k + 20 <= rec_n; k++) begin
      bit same;
      same = 1;
      for (int i = 0; i < 20; i++) if (rec[k + i] != sent[8 + i]) same = 0;
      if (same) hit = 1;
    end
    chk(hit == 1, req, hit, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; smp_en = 0; raw_in = 0; ratio = 6'd16; rec_dis = 0;
    repeat (3) @(negedge clk);
    raw_in = 1;
    smp_en = 1;
    repeat (2) @(negedge clk);
    chk(dat_out == 1'b0, "R1 dat_out in reset", int'(dat_out), 0);
    chk(clk_out == 1'b0, "R1 clk_out in reset", int'(clk_out), 0);
    raw_in = 0;
    rst_n  = 1;
    repeat (4) @(negedge clk);

    // R5 free-running period and high time
    free_run(8, 1, "R5");
    free_run(13, 1, "R5");
    free_run(32, 1, "R5");
    // R9 strobe every other clock
    free_run(10, 2, "R9");
    // R6 clamping
    free_run(3, 1, "R6");
    free_run(45, 1, "R6");

    // R10 resync latency
    latency(8);
    latency(17);

    // R4 glitch rejection, both polarities
    ratio = 6'd16;
    sdiv  = 1;
    hold(1'b0, 64);
    cnt1 = 0;
    strobe(1'b1);
    hold(1'b0, 48);
    chk(cnt1 == 0, "R4 high glitch", cnt1, 0);
    hold(1'b1, 64);
    cnt0 = 0;
    strobe(1'b0);
    hold(1'b1, 48);
    chk(cnt0 == 0, "R4 low glitch", cnt0, 0);

    // R7 nominal-length recovery, R8 jittered recovery
    for (int t = 0; t < 4; t++) recovery(1'b0, "R7");
    for (int t = 0; t < 4; t++) recovery(1'b1, "R8");

    // R3 data only moved on falling clock through all of the above
    chk(viol == 0, "R3 data change outside clk fall", viol, 0);

    // R2 bypass
    rec_dis = 1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      raw_in = 1'($urandom % 2);
      smp_en = 1'($urandom % 2);
      #3;
      chk(dat_out == raw_in && clk_out == 1'b0, "R2 bypass",
          int'({dat_out, clk_out}), int'({raw_in, 1'b0}));
    end
    rec_dis = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule